// File: doc/BRIEF.md
# Breakpoint Value Register Access Guard

This block sits between the system-register access path of a processor core and a file of breakpoint value registers. Each request names a register with a 4-bit number, widened by a bank-select input so that up to 64 registers of 64 bits each can be reached. The request also carries a read/write flag, write data and the exception level it was issued from. Before any access takes place, the block works through a fixed-priority chain of legality checks. Control-bit inputs drive that chain, and they describe the trap configuration of the higher exception levels, the OS lock, and whether external debug may halt the core.

Every request gets one response, one cycle later. The response carries an outcome code: success, undefined, trap to EL2, trap to EL3, or debug halt. On traps it also carries the exception class for the core's exception entry logic. A successful read returns the stored register value. Only a write that clears every check changes the file.

Top module: `bkpt_value_access`

## Requirements
- R1: After reset, every register of the file reads as zero, and no response is flagged valid until a request arrives.
- R2: The register index is the request number plus 16 times the bank select. When the index is equal to or above the implemented count (parameter, default 40), the outcome is undefined (code 1), whatever any other input says.
- R3: A request issued from EL0 (level code 0) always gets outcome undefined (code 1).
- R4: At EL1 (level code 1) the checks apply in a fixed order, and the first one that hits decides the outcome. First, the EL3 priority-undefined input together with the EL3 trap bit gives undefined (1). Second, the fine-grain trap gives a trap to EL2 (2). Third, either EL2 debug trap bit, when EL2 is enabled, gives a trap to EL2 (2). Fourth, the EL3 trap bit applies. Fifth, the halt check applies. If no check hits, the outcome is success (0).
- R5: The fine-grain check applies only when EL2 is enabled and, with EL3 present, only when the EL3 fine-grain enable is set. It uses the read-trap bit for reads and the write-trap bit for writes, and it ignores the other bit.
- R6: When the EL3 trap bit is set and no earlier check has hit, the outcome is undefined (1) if the secure-debug-disable input is high, and a trap to EL3 (3) otherwise.
- R7: At EL2 (level code 2), the fine-grain check and the EL2 trap checks are skipped. At EL3 (level code 3), only the halt check applies.
- R8: A debug halt (code 4) happens when the OS lock input is clear, halting is allowed and the external debug trap bit is set.
- R9: A response with a trap outcome (codes 2 and 3) carries exception class 0x18. Every other response carries exception class 0.
- R10: A write updates the addressed register only when its outcome is success. A write with any other outcome leaves every register unchanged.
- R11: The response is valid exactly one cycle after each request. A successful read returns the stored value in that cycle. Every other response returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_num | input | 4 | Register number within the bank |
| req_bank | input | 2 | Bank select, adds 16 per step to the index |
| req_el | input | 2 | Exception level of the requester |
| req_wdata | input | 64 | Write data |
| cfg_el2_on | input | 1 | EL2 is enabled for the current state |
| cfg_fg_rd_trap | input | 1 | Fine-grain trap of reads to EL2 |
| cfg_fg_wr_trap | input | 1 | Fine-grain trap of writes to EL2 |
| cfg_el3_fg_en | input | 1 | EL3 permits fine-grain trapping |
| cfg_el2_trap_a | input | 1 | First EL2 debug trap bit |
| cfg_el2_trap_b | input | 1 | Second EL2 debug trap bit |
| cfg_el3_trap | input | 1 | EL3 debug trap bit |
| cfg_el3_undef_first | input | 1 | EL3 trap condition is reported as undefined at top priority |
| cfg_sec_dbg_off | input | 1 | Secure debug disabled: EL3 trap becomes undefined |
| cfg_os_lock | input | 1 | OS lock is set |
| cfg_halt_ok | input | 1 | Halting is allowed |
| cfg_ext_trap | input | 1 | External debugger traps software access |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 3 | 0 ok, 1 undefined, 2 trap EL2, 3 trap EL3, 4 halt |
| rsp_ec | output | 6 | Exception class for traps |
| rsp_rdata | output | 64 | Read data |

## Verification
Some properties are checked on every cycle. Each request gives a valid response on the next cycle and only then. EL0 and out-of-range indices always give undefined. Requests at EL3 never give a trap. The trap outcomes always carry the right exception class. The finer points of check order can only be shown by the bench's scenarios. These include the read/write selection of the fine-grain bit and the secure-debug choice between undefined and an EL3 trap. The bench also shows that blocked writes leave the file untouched and that banked indices reach distinct registers.

// File: rtl/bkv_pkg.sv
package bkv_pkg;
  typedef enum logic [2:0] {
    OUT_OK       = 3'd0,
    OUT_UNDEF    = 3'd1,
    OUT_TRAP_EL2 = 3'd2,
    OUT_TRAP_EL3 = 3'd3,
    OUT_HALT     = 3'd4
  } outcome_e;

  localparam logic [5:0] TRAP_EC = 6'h18;
  localparam logic [1:0] LVL_EL0 = 2'd0;
  localparam logic [1:0] LVL_EL1 = 2'd1;
  localparam logic [1:0] LVL_EL2 = 2'd2;
  localparam logic [1:0] LVL_EL3 = 2'd3;

  typedef struct packed {
    logic el2_on;
    logic fg_rd_trap;
    logic fg_wr_trap;
    logic el3_fg_en;
    logic el2_trap_a;
    logic el2_trap_b;
    logic el3_trap;
    logic el3_undef_first;
    logic sec_dbg_off;
    logic os_lock;
    logic halt_ok;
    logic ext_trap;
  } cfg_t;
endpackage

// File: rtl/bkv_index.sv
module bkv_index #(
  parameter int NUM_W    = 4,
  parameter int BANK_W   = 2,
  parameter bit BANKED   = 1'b1,
  parameter int NUM_REGS = 40,
  localparam int IDX_W   = BANKED ? NUM_W + BANK_W : NUM_W
) (
  input  logic [NUM_W-1:0]  num,
  input  logic [BANK_W-1:0] bank,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range
);
  generate
    if (BANKED) begin : g_banked
      assign idx = {bank, num};
    end else begin : g_flat
      logic unused_bank;
      assign unused_bank = ^bank;
      assign idx = num;
    end
  endgenerate

  assign in_range = ({1'b0, idx} < (IDX_W + 1)'(NUM_REGS));
endmodule

// File: rtl/bkv_guard.sv
module bkv_guard
  import bkv_pkg::*;
#(
  parameter bit HAVE_EL3 = 1'b1
) (
  input  logic       in_range,
  input  logic       is_write,
  input  logic [1:0] el,
  input  cfg_t       cfg,
  output outcome_e   verdict,
  output logic [5:0] ec
);
  logic fg_allowed, fg_hit, el2_hit, el3_first, el3_hit, halt_hit;
  outcome_e el3_result;

  always_comb begin
    fg_allowed = cfg.el2_on && (!HAVE_EL3 || cfg.el3_fg_en);
    fg_hit     = fg_allowed && (is_write ? cfg.fg_wr_trap : cfg.fg_rd_trap);
    el2_hit    = cfg.el2_on && (cfg.el2_trap_a || cfg.el2_trap_b);
    el3_first  = HAVE_EL3 && cfg.el3_undef_first && cfg.el3_trap;
    el3_hit    = HAVE_EL3 && cfg.el3_trap;
    el3_result = cfg.sec_dbg_off ? OUT_UNDEF : OUT_TRAP_EL3;
    halt_hit   = !cfg.os_lock && cfg.halt_ok && cfg.ext_trap;
  end

  always_comb begin
    verdict = OUT_OK;
    if (!in_range) begin
      verdict = OUT_UNDEF;
    end else begin
      case (el)
        LVL_EL0: verdict = OUT_UNDEF;
        LVL_EL1: begin
          if (el3_first)     verdict = OUT_UNDEF;
          else if (fg_hit)   verdict = OUT_TRAP_EL2;
          else if (el2_hit)  verdict = OUT_TRAP_EL2;
          else if (el3_hit)  verdict = el3_result;
          else if (halt_hit) verdict = OUT_HALT;
        end
        LVL_EL2: begin
          if (el3_first)     verdict = OUT_UNDEF;
          else if (el3_hit)  verdict = el3_result;
          else if (halt_hit) verdict = OUT_HALT;
        end
        default: begin
          if (halt_hit)      verdict = OUT_HALT;
        end
      endcase
    end
  end

  always_comb begin
    ec = '0;
    if (verdict == OUT_TRAP_EL2 || verdict == OUT_TRAP_EL3) ec = TRAP_EC;
  end

  always_comb begin
    if (!in_range) assert (verdict == OUT_UNDEF);                          // R2
    if (in_range && el == LVL_EL0) assert (verdict == OUT_UNDEF);          // R3
  end
endmodule

// File: rtl/bkv_regfile.sv
module bkv_regfile #(
  parameter int NUM_REGS = 40,
  parameter int DATA_W   = 64,
  parameter int IDX_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];
  logic [DATA_W-1:0] rdata_d, rdata_q;

  always_comb begin
    rdata_d = '0;
    if (rd_en && int'(idx) < NUM_REGS) rdata_d = mem_q[idx];
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic we;
      assign we = wr_en && (int'(idx) == g);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mem_q[g] <= '0;
        else if (we) mem_q[g] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  AST_RD_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rdata == '0);                                              // R11
endmodule

// File: rtl/bkpt_value_access.sv
module bkpt_value_access
  import bkv_pkg::*;
#(
  parameter int NUM_REGS = 40,
  parameter int DATA_W   = 64,
  parameter int NUM_W    = 4,
  parameter int BANK_W   = 2,
  parameter bit BANKED   = 1'b1,
  parameter bit HAVE_EL3 = 1'b1,
  localparam int IDX_W   = BANKED ? NUM_W + BANK_W : NUM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [NUM_W-1:0]  req_num,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [1:0]        req_el,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cfg_el2_on,
  input  logic              cfg_fg_rd_trap,
  input  logic              cfg_fg_wr_trap,
  input  logic              cfg_el3_fg_en,
  input  logic              cfg_el2_trap_a,
  input  logic              cfg_el2_trap_b,
  input  logic              cfg_el3_trap,
  input  logic              cfg_el3_undef_first,
  input  logic              cfg_sec_dbg_off,
  input  logic              cfg_os_lock,
  input  logic              cfg_halt_ok,
  input  logic              cfg_ext_trap,
  output logic              rsp_valid,
  output logic [2:0]        rsp_code,
  output logic [5:0]        rsp_ec,
  output logic [DATA_W-1:0] rsp_rdata
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cfg_t             cfg;
  logic [IDX_W-1:0] idx;
  logic             in_range;
  outcome_e         verdict;
  logic [5:0]       ec_d;
  logic             wr_en, rd_en;

  assign cfg = '{el2_on: cfg_el2_on, fg_rd_trap: cfg_fg_rd_trap,
                 fg_wr_trap: cfg_fg_wr_trap, el3_fg_en: cfg_el3_fg_en,
                 el2_trap_a: cfg_el2_trap_a, el2_trap_b: cfg_el2_trap_b,
                 el3_trap: cfg_el3_trap, el3_undef_first: cfg_el3_undef_first,
                 sec_dbg_off: cfg_sec_dbg_off, os_lock: cfg_os_lock,
                 halt_ok: cfg_halt_ok, ext_trap: cfg_ext_trap};

  bkv_index #(.NUM_W(NUM_W), .BANK_W(BANK_W), .BANKED(BANKED), .NUM_REGS(NUM_REGS))
  u_index (.num(req_num), .bank(req_bank), .idx(idx), .in_range(in_range));

  bkv_guard #(.HAVE_EL3(HAVE_EL3))
  u_guard (.in_range(in_range), .is_write(req_write), .el(req_el), .cfg(cfg),
           .verdict(verdict), .ec(ec_d));

  assign wr_en = req_valid && req_write  && (verdict == OUT_OK);
  assign rd_en = req_valid && !req_write && (verdict == OUT_OK);

  bkv_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W))
  u_file (.clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .rd_en(rd_en), .idx(idx),
          .wdata(req_wdata), .rdata(rsp_rdata));

  // response stage: next state then register
  logic       valid_d, valid_q;
  logic [2:0] code_d, code_q;
  logic [5:0] ec_nx, ec_q;

  always_comb begin
    valid_d = req_valid;
    code_d  = req_valid ? verdict : OUT_OK;
    ec_nx   = req_valid ? ec_d : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
      ec_q    <= '0;
    end else begin
      valid_q <= valid_d;
      code_q  <= code_d;
      ec_q    <= ec_nx;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_code  = code_q;
  assign rsp_ec    = ec_q;

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |=> rsp_valid);                                             // R11
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> !rsp_valid);                                           // R11
  AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_el == LVL_EL0) |=> rsp_code == OUT_UNDEF);          // R3
  AST_RANGE_UNDEF: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && ({1'b0, req_bank, req_num} >= (BANK_W + NUM_W + 1)'(NUM_REGS)))
    |=> rsp_code == OUT_UNDEF);                                           // R2
  AST_EL3_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_el == LVL_EL3)
    |=> (rsp_code != OUT_TRAP_EL2 && rsp_code != OUT_TRAP_EL3));          // R7
  AST_TRAP_EC: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && (rsp_code == OUT_TRAP_EL2 || rsp_code == OUT_TRAP_EL3))
    |-> rsp_ec == TRAP_EC);                                               // R9
endmodule

// File: tb/bkpt_value_access_test.sv
module bkpt_value_access_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_num = '0;
  logic [1:0]  req_bank = '0, req_el = '0;
  logic [63:0] req_wdata = '0;
  logic [11:0] ctl = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_code;
  logic [5:0]  rsp_ec;
  logic [63:0] rsp_rdata;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bkpt_value_access uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_num(req_num), .req_bank(req_bank), .req_el(req_el), .req_wdata(req_wdata),
    .cfg_el2_on(ctl[11]), .cfg_fg_rd_trap(ctl[10]), .cfg_fg_wr_trap(ctl[9]),
    .cfg_el3_fg_en(ctl[8]), .cfg_el2_trap_a(ctl[7]), .cfg_el2_trap_b(ctl[6]),
    .cfg_el3_trap(ctl[5]), .cfg_el3_undef_first(ctl[4]), .cfg_sec_dbg_off(ctl[3]),
    .cfg_os_lock(ctl[2]), .cfg_halt_ok(ctl[1]), .cfg_ext_trap(ctl[0]),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_ec(rsp_ec), .rsp_rdata(rsp_rdata));

  localparam logic [2:0] OK = 3'd0, UD = 3'd1, T2 = 3'd2, T3 = 3'd3, HL = 3'd4;

  // {req tag, write, el, bank, num, ctl, expected code}
  function automatic logic [27:0] v(input logic [3:0] r, input logic w,
      input logic [1:0] el, input logic [1:0] bk, input logic [3:0] n,
      input logic [11:0] c, input logic [2:0] e);
    return {r, w, el, bk, n, c, e};
  endfunction

  // ctl bits: el2_on fg_rd fg_wr el3_fg | trapA trapB el3_trap el3_first | sdd oslock halt_ok ext
  localparam int NV = 27;
  localparam logic [27:0] VEC [NV] = '{
    v(4'd4, 0, 1, 0, 3,  12'b0000_0000_0000, OK),  // R4 nothing set
    v(4'd3, 0, 0, 0, 3,  12'b0000_0000_0000, UD),  // R3
    v(4'd2, 0, 1, 2, 8,  12'b0000_0010_0000, UD),  // R2 index 40
    v(4'd2, 0, 3, 3, 15, 12'b0000_0000_0011, UD),  // R2 index 63
    v(4'd4, 0, 1, 0, 1,  12'b1101_0011_0000, UD),  // R4 first check wins
    v(4'd5, 0, 1, 0, 1,  12'b1101_0000_0000, T2),  // R5 read trap
    v(4'd5, 0, 1, 0, 1,  12'b1011_0000_0000, OK),  // R5 write bit ignored on read
    v(4'd5, 1, 1, 0, 1,  12'b1011_0000_0000, T2),  // R5 write trap
    v(4'd5, 0, 1, 0, 1,  12'b1100_0000_0000, OK),  // R5 not permitted by EL3
    v(4'd4, 0, 1, 0, 2,  12'b1000_1000_0000, T2),  // R4 trap a
    v(4'd4, 0, 1, 0, 2,  12'b1000_0100_0000, T2),  // R4 trap b
    v(4'd4, 0, 1, 0, 2,  12'b0000_1100_0000, OK),  // R4 EL2 disabled
    v(4'd6, 0, 1, 1, 0,  12'b0000_0010_0000, T3),  // R6 trap EL3
    v(4'd6, 0, 1, 1, 0,  12'b0000_0010_1000, UD),  // R6 secure debug off
    v(4'd4, 0, 1, 0, 4,  12'b1000_1010_0000, T2),  // R4 EL2 before EL3
    v(4'd4, 0, 1, 0, 4,  12'b0000_0010_0011, T3),  // R4 EL3 before halt
    v(4'd8, 0, 1, 0, 4,  12'b0000_0000_0011, HL),  // R8
    v(4'd8, 0, 1, 0, 4,  12'b0000_0000_0111, OK),  // R8 OS lock
    v(4'd8, 0, 1, 0, 4,  12'b0000_0000_0001, OK),  // R8 halting not allowed
    v(4'd8, 0, 1, 0, 4,  12'b0000_0000_0010, OK),  // R8 ext trap clear
    v(4'd7, 0, 2, 0, 5,  12'b1101_1100_0000, OK),  // R7 EL2 skips
    v(4'd7, 0, 2, 0, 5,  12'b0000_0010_0000, T3),  // R7
    v(4'd7, 0, 2, 0, 5,  12'b0000_0011_0000, UD),  // R7
    v(4'd7, 0, 2, 0, 5,  12'b0000_0000_0011, HL),  // R7
    v(4'd7, 0, 3, 0, 5,  12'b1111_1111_1000, OK),  // R7 EL3 ignores traps
    v(4'd7, 0, 3, 0, 5,  12'b1111_1111_1011, HL),  // R7 EL3 halt
    v(4'd2, 0, 3, 2, 7,  12'b0000_0000_0000, OK)   // R2 index 39
  };

  task automatic access(input logic w, input logic [1:0] el, input logic [1:0] bk,
                        input logic [3:0] n, input logic [11:0] c, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_el = el; req_bank = bk; req_num = n;
    ctl = c; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; ctl = '0;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_rsp(input string tag, input logic [2:0] code, input logic [63:0] data);
    chk({tag, " valid"}, {63'd0, rsp_valid}, 64'd1);
    chk({tag, " code"}, {61'd0, rsp_code}, {61'd0, code});
    chk({tag, " data"}, rsp_rdata, data);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 idle valid", {63'd0, rsp_valid}, 64'd0);
    access(0, 1, 0, 0, '0, '0);  chk_rsp("R1 reg0", OK, 64'd0);
    access(0, 1, 1, 1, '0, '0);  chk_rsp("R1 reg17", OK, 64'd0);
    access(0, 1, 2, 7, '0, '0);  chk_rsp("R1 reg39", OK, 64'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [2:0] e;
      logic [5:0] xec;
      e = VEC[i][2:0];
      access(VEC[i][23], VEC[i][22:21], VEC[i][20:19], VEC[i][18:15], VEC[i][14:3], '0);
      checks++;
      if (rsp_code !== e || rsp_valid !== 1'b1) begin
        errors++;
        $display("FAIL vec %0d R%0d actual=%0d expected=%0d", i, VEC[i][27:24], rsp_code, e);
      end
      xec = (e == T2 || e == T3) ? 6'h18 : 6'h00;
      chk($sformatf("R9 vec %0d ec", i), {58'd0, rsp_ec}, {58'd0, xec});
    end

    // R10/R11: write then read back
    access(1, 1, 0, 5, '0, 64'hA5A5_0000_1234_5678); chk_rsp("R10 write ok", OK, 64'd0);
    access(0, 1, 0, 5, '0, '0); chk_rsp("R11 readback", OK, 64'hA5A5_0000_1234_5678);
    @(negedge clk);
    chk("R11 no request no valid", {63'd0, rsp_valid}, 64'd0);

    // R2: bank extends the index
    access(1, 2, 1, 1, '0, 64'hBEEF_0017);
    access(0, 1, 0, 1, '0, '0); chk_rsp("R2 reg1 untouched", OK, 64'd0);
    access(0, 1, 1, 1, '0, '0); chk_rsp("R2 reg17", OK, 64'hBEEF_0017);

    // R10: blocked writes leave the file unchanged
    access(1, 0, 0, 5, '0, 64'hDEAD); chk_rsp("R10 EL0 write", UD, 64'd0);
    access(1, 1, 0, 5, 12'b1011_0000_0000, 64'hDEAD); chk_rsp("R10 fg write", T2, 64'd0);
    access(1, 1, 0, 5, 12'b0000_0000_0011, 64'hDEAD); chk_rsp("R10 halt write", HL, 64'd0);
    access(1, 1, 0, 5, 12'b0000_0010_0000, 64'hDEAD); chk_rsp("R10 EL3 trap write", T3, 64'd0);
    access(0, 1, 0, 5, '0, '0); chk_rsp("R10 reg5 kept", OK, 64'hA5A5_0000_1234_5678);
    access(0, 1, 0, 5, 12'b1101_0000_0000, '0); chk_rsp("R11 blocked read data", T2, 64'd0);

    // R7: EL3 write passes despite trap bits
    access(1, 3, 2, 7, 12'b1111_1111_1000, 64'h3333); chk_rsp("R7 EL3 write", OK, 64'd0);
    access(0, 3, 2, 7, '0, '0); chk_rsp("R7 EL3 read", OK, 64'h3333);

    // R1: reset clears the file
    do_reset();
    access(0, 1, 0, 5, '0, '0); chk_rsp("R1 reg5 after reset", OK, 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule